// File: doc/BRIEF.md
# Oversampling Serial Receiver with Majority Voting

This block receives asynchronous serial frames on a single line that idles high. An external rate generator supplies a one-cycle enable pulse, `tick16`, sixteen times per bit period. The receiver synchronizes the line into the core clock domain and detects a falling edge between two consecutive ticks as the start of a frame. It then decides every bit from three samples taken in the middle of that bit. Sample timing restarts on each start edge, so clock drift only builds up over one frame.

A frame has one start bit, eight or nine payload bits sent LSB first, and one stop bit. When parity is enabled, the last payload slot carries a parity bit instead of data. The received word is presented with a one-cycle valid strobe. Three sticky flags report a split vote, a parity mismatch and a low stop bit. A parity interrupt request follows the parity flag when its enable is set.

Top module: `uart_os_rx`

## Requirements
- R1: Each `tick16` pulse takes one sample of the synchronized line. A frame begins when one tick sees the line high and the next tick sees it low. That low sample is sample 1 of the start bit, and each bit spans 16 samples.
- R2: Every bit (start, payload and stop) takes the 2-of-3 majority of its samples 8, 9 and 10.
- R3: If the three voting samples of any bit in a delivered frame do not all agree, `noise_flg` is set when that frame is delivered.
- R4: If the start bit votes high, the receiver drops the frame, delivers nothing and waits for a new falling edge.
- R5: With `frame9` low, a frame carries 8 payload bits; with `frame9` high, it carries 9. Payload bits are received LSB first into `rx_word[0]` upward, and bits of `rx_word` above the frame length read 0.
- R6: With `par_en` high, the highest payload slot (bit 7 for 8-bit frames, bit 8 for 9-bit frames) holds parity and is delivered as 0 in `rx_word`. The bits below it are data.
- R7: With `par_en` high, the ones over all payload slots, parity slot included, must be even when `par_odd` is 0 and odd when `par_odd` is 1. A mismatch sets `par_err`. With `par_en` low, `par_err` is never set.
- R8: A stop bit that votes low sets `frm_err`, and the word is still delivered.
- R9: `rx_valid` is high for exactly one clock cycle per delivered frame, in the cycle after the tick that takes sample 10 of the stop bit.
- R10: The flags stay set until `flag_clr` is pulsed. A pulse clears all three unless a frame is delivered at the same edge, in which case that frame's conditions are kept.
- R11: `irq` is high one cycle after `par_err` is high while `par_irq_en` is high, and is low otherwise.
- R12: After reset, `rx_word`, `rx_valid`, every flag and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Sampling enable, 16 pulses per bit |
| rx_in | input | 1 | Asynchronous serial line, idles high |
| frame9 | input | 1 | 0: 8 payload bits, 1: 9 payload bits |
| par_en | input | 1 | Top payload slot carries parity |
| par_odd | input | 1 | 0: even parity, 1: odd parity |
| par_irq_en | input | 1 | Enables `irq` from the parity flag |
| flag_clr | input | 1 | Pulse that clears the sticky flags |
| rx_word | output | DW (9) | Last received word |
| rx_valid | output | 1 | One-cycle strobe for a new word |
| noise_flg | output | 1 | Sticky split-vote flag |
| par_err | output | 1 | Sticky parity mismatch flag |
| frm_err | output | 1 | Sticky low stop bit flag |
| irq | output | 1 | Parity interrupt request |

## Verification
The bench sweeps all eight combinations of frame length, parity enable and parity sense over spread payloads that include all-zeros and all-ones. It sends a wrong parity bit on alternate frames, so swapped parity senses, a parity slot off by one position and a missing LSB mask all change the delivered word or the flag. Directed frames corrupt one voting sample, which must leave the bit unchanged but raise noise. Other frames corrupt two voting samples, which must flip the bit; a design that votes on the wrong sample positions would decide these bits wrongly. A short low glitch must not produce a word. A low stop bit must still deliver the word, and its flag must survive a later clean frame until a clear pulse arrives.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] pipe;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[i] <= 1'b1;
          else     pipe[i] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[i] <= 1'b1;
          else     pipe[i] <= pipe[i-1];
        end
      end
    end
  endgenerate

  assign d_out = pipe[STAGES-1];
endmodule

// File: rtl/rx_vote.sv
module rx_vote (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic maj,
  output logic split
);
  always_comb begin
    maj   = (a & b) | (a & c) | (b & c);
    split = (a != b) || (b != c);
  end
endmodule

// File: rtl/rx_deframe.sv
module rx_deframe
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rx_s,
  input  logic          frame9,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          flag_clr,
  output logic [DW-1:0] word_o,
  output logic          valid_o,
  output logic          noise_o,
  output logic          perr_o,
  output logic          ferr_o
);
  localparam int CW    = $clog2(OSR + 1);
  localparam int IW    = $clog2(DW);
  localparam int MID_A = OSR / 2;
  localparam int MID_B = MID_A + 1;
  localparam int MID_C = MID_A + 2;

  rx_state_e     state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] ncnt;
  logic [IW-1:0] bit_idx;
  logic [IW-1:0] last_idx;
  logic          rx_prev;
  logic          smp_a, smp_b;
  logic          fr_noise;
  logic [DW-1:0] shreg;
  logic          maj, split;
  logic [DW-1:0] word_n;
  logic          perr_n;
  logic          keep_n, keep_p, keep_f;

  rx_vote u_vote (
    .a     (smp_a),
    .b     (smp_b),
    .c     (rx_s),
    .maj   (maj),
    .split (split)
  );

  always_comb begin
    ncnt     = cnt + 1'b1;
    last_idx = frame9 ? IW'(DW - 1) : IW'(DW - 2);
    word_n   = shreg;
    if (par_en) word_n[last_idx] = 1'b0;
    perr_n   = par_en && ((^shreg) ^ par_odd);
    keep_n   = flag_clr ? 1'b0 : noise_o;
    keep_p   = flag_clr ? 1'b0 : perr_o;
    keep_f   = flag_clr ? 1'b0 : ferr_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RX_IDLE;
      cnt      <= '0;
      bit_idx  <= '0;
      rx_prev  <= 1'b1;
      smp_a    <= 1'b1;
      smp_b    <= 1'b1;
      fr_noise <= 1'b0;
      shreg    <= '0;
      word_o   <= '0;
      valid_o  <= 1'b0;
      noise_o  <= 1'b0;
      perr_o   <= 1'b0;
      ferr_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (flag_clr) begin
        noise_o <= 1'b0;
        perr_o  <= 1'b0;
        ferr_o  <= 1'b0;
      end
      if (tick) begin
        rx_prev <= rx_s;
        if (state == RX_IDLE) begin
          if (rx_prev && !rx_s) begin
            state    <= RX_START;
            cnt      <= CW'(1);
            bit_idx  <= '0;
            fr_noise <= 1'b0;
            shreg    <= '0;
          end
        end else begin
          cnt <= (ncnt == CW'(OSR)) ? '0 : ncnt;
          if (ncnt == CW'(MID_A)) smp_a <= rx_s;
          if (ncnt == CW'(MID_B)) smp_b <= rx_s;
          if (ncnt == CW'(MID_C)) begin
            case (state)
              RX_START: begin
                if (maj) state <= RX_IDLE;
                else     fr_noise <= split;
              end
              RX_DATA: begin
                shreg[bit_idx] <= maj;
                fr_noise       <= fr_noise | split;
              end
              RX_STOP: begin
                word_o  <= word_n;
                valid_o <= 1'b1;
                noise_o <= keep_n | fr_noise | split;
                perr_o  <= keep_p | perr_n;
                ferr_o  <= keep_f | !maj;
                state   <= RX_IDLE;
              end
              default: state <= RX_IDLE;
            endcase
          end
          if (ncnt == CW'(OSR)) begin
            case (state)
              RX_START: state <= RX_DATA;
              RX_DATA: begin
                if (bit_idx == last_idx) state <= RX_STOP;
                else bit_idx <= bit_idx + 1'b1;
              end
              default: ;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx #(
  parameter int OSR         = 16,
  parameter int DW          = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick16,
  input  logic          rx_in,
  input  logic          frame9,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          par_irq_en,
  input  logic          flag_clr,
  output logic [DW-1:0] rx_word,
  output logic          rx_valid,
  output logic          noise_flg,
  output logic          par_err,
  output logic          frm_err,
  output logic          irq
);
  logic rx_s;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (rx_in),
    .d_out (rx_s)
  );

  rx_deframe #(.OSR(OSR), .DW(DW)) u_deframe (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick16),
    .rx_s     (rx_s),
    .frame9   (frame9),
    .par_en   (par_en),
    .par_odd  (par_odd),
    .flag_clr (flag_clr),
    .word_o   (rx_word),
    .valid_o  (rx_valid),
    .noise_o  (noise_flg),
    .perr_o   (par_err),
    .ferr_o   (frm_err)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= par_irq_en && par_err;
  end
endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk #(
  parameter int DW = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          frame9,
  input logic          par_en,
  input logic          par_irq_en,
  input logic          flag_clr,
  input logic [DW-1:0] rx_word,
  input logic          rx_valid,
  input logic          noise_flg,
  input logic          par_err,
  input logic          frm_err,
  input logic          irq
);
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid); // R9
  AST_NOISE_AT_END: assert property (@(posedge clk) disable iff (rst)
    $rose(noise_flg) |-> rx_valid); // R3
  AST_PERR_AT_END: assert property (@(posedge clk) disable iff (rst)
    $rose(par_err) |-> rx_valid); // R7
  AST_FERR_AT_END: assert property (@(posedge clk) disable iff (rst)
    $rose(frm_err) |-> rx_valid); // R8
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(flag_clr) && !rx_valid |-> !noise_flg && !par_err && !frm_err); // R10
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    !par_irq_en && !$past(par_irq_en) |-> !irq); // R11
  AST_SHORT_FRAME_TOP: assert property (@(posedge clk) disable iff (rst)
    rx_valid && !frame9 |-> !rx_word[DW-1]); // R5
  AST_PARITY_SLOT_ZERO: assert property (@(posedge clk) disable iff (rst)
    rx_valid && par_en |-> !rx_word[frame9 ? DW-1 : DW-2]); // R6
endmodule

bind uart_os_rx uart_os_rx_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .frame9     (frame9),
  .par_en     (par_en),
  .par_irq_en (par_irq_en),
  .flag_clr   (flag_clr),
  .rx_word    (rx_word),
  .rx_valid   (rx_valid),
  .noise_flg  (noise_flg),
  .par_err    (par_err),
  .frm_err    (frm_err),
  .irq        (irq)
);

// File: tb/tb_uart_os_rx.sv
module tb_uart_os_rx;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick16 = 1'b0;
  logic rx_in = 1'b1;
  logic frame9 = 1'b0, par_en = 1'b0, par_odd = 1'b0, par_irq_en = 1'b0, flag_clr = 1'b0;
  logic [DW-1:0] rx_word;
  logic rx_valid, noise_flg, par_err, frm_err, irq;

  int total = 0;
  int bad = 0;
  int vcount = 0;
  logic [DW-1:0] last_word = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_os_rx dut (
    .clk(clk), .rst(rst), .tick16(tick16), .rx_in(rx_in),
    .frame9(frame9), .par_en(par_en), .par_odd(par_odd),
    .par_irq_en(par_irq_en), .flag_clr(flag_clr),
    .rx_word(rx_word), .rx_valid(rx_valid), .noise_flg(noise_flg),
    .par_err(par_err), .frm_err(frm_err), .irq(irq)
  );

  always @(negedge clk) begin
    if (!rst && rx_valid) begin
      vcount    <= vcount + 1;
      last_word <= rx_word;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic smp(input logic v);
    rx_in = v;
    repeat (3) @(negedge clk);
    tick16 = 1'b1;
    @(negedge clk);
    tick16 = 1'b0;
  endtask

  // mode 0 clean, 1 sample 8 inverted, 2 samples 8 and 9 inverted, 3 only samples 1..6 at v
  task automatic send_bit(input logic v, input int mode);
    for (int s = 1; s <= 16; s++) begin
      logic o;
      o = v;
      if (mode == 1 && s == 8) o = ~v;
      if (mode == 2 && (s == 8 || s == 9)) o = ~v;
      if (mode == 3 && s > 6) o = ~v;
      smp(o);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) smp(1'b1);
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  // sends a frame; nb payload slots; slot bad_slot uses bad_mode
  task automatic send_frame(input logic [DW-1:0] slots, input int nb, input logic stop_v,
                            input int bad_slot, input int bad_mode);
    idle(2);
    send_bit(1'b0, 0);
    for (int i = 0; i < nb; i++) send_bit(slots[i], (i == bad_slot) ? bad_mode : 0);
    send_bit(stop_v, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(rx_word == 0 && !rx_valid, "R12 word/valid", {rx_word, rx_valid}, 0);
    chk(!noise_flg && !par_err && !frm_err && !irq, "R12 flags",
        {noise_flg, par_err, frm_err, irq}, 0);

    // sweep: R1 R2 R5 R6 R7 R9 R11
    for (int cfg = 0; cfg < 8; cfg++) begin
      for (int k = 0; k < 12; k++) begin
        int nb;
        logic [DW-1:0] d, slots, expw;
        logic wrong, pbit, expp, expi;
        int v0;
        frame9 = cfg[0]; par_en = cfg[1]; par_odd = cfg[2];
        par_irq_en = k[1];
        nb = frame9 ? 9 : 8;
        d = (k == 0) ? 9'h000 : (k == 1) ? 9'h1FF : DW'((k * 37 + cfg * 11 + 5) & 9'h1FF);
        wrong = par_en && k[0];
        slots = '0;
        expw = '0;
        if (par_en) begin
          pbit = par_odd;
          for (int i = 0; i < nb - 1; i++) begin
            slots[i] = d[i];
            expw[i] = d[i];
            pbit = pbit ^ d[i];
          end
          slots[nb-1] = pbit ^ wrong;
        end else begin
          for (int i = 0; i < nb; i++) begin
            slots[i] = d[i];
            expw[i] = d[i];
          end
        end
        expp = wrong;
        expi = expp && par_irq_en;
        pulse_clr();
        v0 = vcount;
        send_frame(slots, nb, 1'b1, -1, 0);
        chk(vcount == v0 + 1, "R9 one strobe per frame", vcount - v0, 1);
        chk(last_word == expw, "R5/R6 word", last_word, expw);
        chk(par_err == expp, "R7 parity flag", par_err, expp);
        chk(!noise_flg && !frm_err, "R3/R8 clean frame flags", {noise_flg, frm_err}, 0);
        chk(irq == expi, "R11 irq", irq, expi);
      end
    end

    frame9 = 1'b0; par_en = 1'b0; par_odd = 1'b0; par_irq_en = 1'b0;

    // R2 R3 one voting sample wrong: bit kept, noise raised
    pulse_clr();
    send_frame(9'h0A5, 8, 1'b1, 3, 1);
    chk(last_word == 9'h0A5, "R2 single split keeps bit", last_word, 9'h0A5);
    chk(noise_flg == 1'b1, "R3 noise on split vote", noise_flg, 1);

    // R2 two voting samples wrong: bit flips
    pulse_clr();
    send_frame(9'h0A5, 8, 1'b1, 2, 2);
    chk(last_word == 9'h0A1, "R2 majority flips bit", last_word, 9'h0A1);
    chk(noise_flg == 1'b1, "R3 noise on flipped bit", noise_flg, 1);

    // R4 false start: short low glitch, then a valid frame
    pulse_clr();
    begin
      int v0;
      v0 = vcount;
      idle(2);
      send_bit(1'b0, 3);
      idle(4);
      chk(vcount == v0, "R4 no word on false start", vcount - v0, 0);
      send_frame(9'h03C, 8, 1'b1, -1, 0);
      chk(vcount == v0 + 1 && last_word == 9'h03C, "R4 recovers after false start",
          last_word, 9'h03C);
      chk(!noise_flg, "R4 glitch adds no noise", noise_flg, 0);
    end

    // R8 framing error still delivers
    pulse_clr();
    begin
      int v0;
      v0 = vcount;
      send_frame(9'h066, 8, 1'b0, -1, 0);
      chk(vcount == v0 + 1 && last_word == 9'h066, "R8 word delivered on bad stop",
          last_word, 9'h066);
      chk(frm_err == 1'b1, "R8 framing flag", frm_err, 1);
    end

    // R10 sticky across a clean frame, cleared by pulse
    send_frame(9'h011, 8, 1'b1, -1, 0);
    chk(frm_err == 1'b1, "R10 flag sticky", frm_err, 1);
    chk(last_word == 9'h011, "R1 next frame after error", last_word, 9'h011);
    pulse_clr();
    @(negedge clk);
    chk(!frm_err && !noise_flg && !par_err, "R10 clear pulse", {noise_flg, par_err, frm_err}, 0);

    // R5 9-bit frame with top bit set
    frame9 = 1'b1;
    send_frame(9'h180, 9, 1'b1, -1, 0);
    chk(last_word == 9'h180, "R5 nine-bit top bit", last_word, 9'h180);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule